// File: doc/BRIEF.md
# Two-Port Shared RAM with Mailbox Interrupts

This block is a clocked two-port memory. It has a left port and a right port, and each one carries its own chip enable, write enable, output enable, address and data. Both ports may reach the array in the same clock cycle, and they may reach the same word. Read data is registered.

The two highest words of the array are set aside as mailboxes between the two sides. A write by one side into the other side's mailbox raises that side's interrupt. The interrupt drops again when its owner reads the mailbox.

When both ports are enabled on the same address, a collision arbiter picks a loser. The arbiter flags the loser with a busy signal and discards any write the loser attempts in that cycle. A strap sets the role of this instance. With the strap high, the instance arbitrates on its own. With the strap low, it takes busy from outside and drives its own busy outputs inactive.

The address width is a parameter, and the mailbox locations follow the top of whatever depth it gives. A width of 17 gives 128K words of 8 bits. The default is kept small.

Top module: `dpram_mailbox`

## Requirements
- R1: After reset, both busy outputs and both interrupt outputs are high (inactive), both read-data outputs are zero, and both mailbox words read as zero.
- R2: A read happens when a port has chip enable low, output enable low and write enable high. The word at that address appears on the port's read data after the next rising clock edge. At any other time the read data holds its last value.
- R3: The two ports may write different words in the same cycle, and both writes take effect. The two ports may read the same word in the same cycle, and both get its value.
- R4: A left-port write to the top address (all ones) drives `rightIntN` low after the next edge. A right-port read of that address returns the written value and drives `rightIntN` high after the next edge.
- R5: A right-port write to the address one below the top drives `leftIntN` low after the next edge. A left-port read of that address returns the value and releases `leftIntN`.
- R6: If one cycle both sets and clears the same interrupt, the interrupt ends up asserted (low).
- R7: With `masterMode` high, suppose both ports are enabled on the same address and neither port held that address alone in the previous cycle. Then `rightBusyN` goes low after the next edge and `leftBusyN` stays high. Busy holds while the match lasts, and it is released the edge after the addresses differ or a chip enable goes high. The two busy outputs are never low together.
- R8: With `masterMode` high, suppose the right port was enabled on an address in the previous cycle and the left port was not on its own address. If the left port now joins the right port on that address, the left port loses and `leftBusyN` goes low.
- R9: With `masterMode` high, a write by the losing port in a collision cycle leaves the array unchanged. The winner's write is stored.
- R10: With `masterMode` low, both busy outputs stay high, even when the addresses collide. A write from a port whose busy input is low changes neither the array nor any interrupt. A write from a port whose busy input is high is stored normally.
- R11: With `masterMode` high, the busy inputs have no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1: arbitrate internally; 0: busy taken from inputs |
| leftCeN | input | 1 | Left chip enable, active low |
| leftWeN | input | 1 | Left write enable, active low |
| leftOeN | input | 1 | Left output enable, active low |
| leftAddr | input | ADDR_W | Left address |
| leftWrData | input | DATA_W | Left write data |
| leftRdData | output | DATA_W | Left registered read data |
| leftBusyInN | input | 1 | Left busy input (used when `masterMode` is low) |
| leftBusyN | output | 1 | Left busy output, active low |
| leftIntN | output | 1 | Left interrupt, active low |
| rightCeN | input | 1 | Right chip enable, active low |
| rightWeN | input | 1 | Right write enable, active low |
| rightOeN | input | 1 | Right output enable, active low |
| rightAddr | input | ADDR_W | Right address |
| rightWrData | input | DATA_W | Right write data |
| rightRdData | output | DATA_W | Right registered read data |
| rightBusyInN | input | 1 | Right busy input (used when `masterMode` is low) |
| rightBusyN | output | 1 | Right busy output, active low |
| rightIntN | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is a collision where the right port holds an address first, so that the left port is the loser. This is the reverse of the default order, and it shows up only when the right port has been enabled alone on the address for one cycle before the left port arrives. The bench builds that history on purpose, then has both ports write the shared word with different data. A read afterwards shows which write survived. The set-over-clear case needs a similar setup. The bench first raises the right interrupt, then in one cycle has the left port write the mailbox while the right port reads it.

// File: rtl/dpram_mailbox_pkg.sv
package dpram_mailbox_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrLeft;
    logic wrRight;
    logic rdLeft;
    logic rdRight;
  } portStrobe_t;

endpackage

// File: rtl/dpram_irq_flag.sv
module dpram_irq_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic clrReq,
  output logic flagN
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b1;
    end else if (setReq) begin
      flagN <= 1'b0;            // set dominates a same-cycle clear
    end else if (clrReq) begin
      flagN <= 1'b1;
    end
  end

endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpram_mailbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       stb,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataL,
  input  logic [DATA_W-1:0] wrDataR,
  output logic [DATA_W-1:0] rdDataL,
  output logic [DATA_W-1:0] rdDataR
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_OF_RIGHT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_OF_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] boxLeftQ;
  logic [DATA_W-1:0] boxRightQ;

  logic isBoxL, isBoxR;
  assign isBoxL = (addrL == BOX_OF_LEFT) || (addrL == BOX_OF_RIGHT);
  assign isBoxR = (addrR == BOX_OF_LEFT) || (addrR == BOX_OF_RIGHT);

  // plain array: right applied first so a same-word left write lands last
  always_ff @(posedge clk) begin
    if (stb.wrRight && !isBoxR) mem[addrR] <= wrDataR;
    if (stb.wrLeft && !isBoxL)  mem[addrL] <= wrDataL;
  end

  // mailbox words live in reset flops
  always_ff @(posedge clk) begin
    if (!rstN) begin
      boxLeftQ  <= '0;
      boxRightQ <= '0;
    end else begin
      if (stb.wrRight && addrR == BOX_OF_LEFT)  boxLeftQ  <= wrDataR;
      if (stb.wrRight && addrR == BOX_OF_RIGHT) boxRightQ <= wrDataR;
      if (stb.wrLeft && addrL == BOX_OF_LEFT)   boxLeftQ  <= wrDataL;
      if (stb.wrLeft && addrL == BOX_OF_RIGHT)  boxRightQ <= wrDataL;
    end
  end

  function automatic logic [DATA_W-1:0] fetch(input logic [ADDR_W-1:0] a);
    if (a == BOX_OF_RIGHT)     return boxRightQ;
    else if (a == BOX_OF_LEFT) return boxLeftQ;
    else                       return mem[a];
  endfunction

  logic [ADDR_W-1:0] rdAddr [2];
  logic              rdEn   [2];
  logic [DATA_W-1:0] rdQ    [2];

  assign rdAddr[0] = addrL;
  assign rdAddr[1] = addrR;
  assign rdEn[0]   = stb.rdLeft;
  assign rdEn[1]   = stb.rdRight;

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdQ[p] <= '0;
      end else if (rdEn[p]) begin
        rdQ[p] <= fetch(rdAddr[p]);
      end
    end
  end

  assign rdDataL = rdQ[0];
  assign rdDataR = rdQ[1];

endmodule

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_mailbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceLN,
  input  logic              weLN,
  input  logic              oeLN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInLN,
  input  logic              ceRN,
  input  logic              weRN,
  input  logic              oeRN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInRN,
  output portStrobe_t       stb,
  output logic              busyLN,
  output logic              busyRN,
  output logic              intLN,
  output logic              intRN
);

  localparam logic [ADDR_W-1:0] BOX_OF_RIGHT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_OF_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic enL, enR, match;
  logic lastEnL, lastEnR;
  logic [ADDR_W-1:0] lastAddrL, lastAddrR;
  logic matchQ;
  side_e loserQ, loserNow;
  logic rightHeldFirst;
  logic blockL, blockR;

  assign enL   = !ceLN;
  assign enR   = !ceRN;
  assign match = enL && enR && (addrL == addrR);

  // right wins only if it sat on the word alone one cycle earlier
  assign rightHeldFirst = lastEnR && (lastAddrR == addrR) &&
                          !(lastEnL && (lastAddrL == addrL));

  always_comb begin
    if (matchQ)              loserNow = loserQ;
    else if (rightHeldFirst) loserNow = SIDE_LEFT;
    else                     loserNow = SIDE_RIGHT;
  end

  assign blockL = masterMode ? (match && loserNow == SIDE_LEFT)  : !busyInLN;
  assign blockR = masterMode ? (match && loserNow == SIDE_RIGHT) : !busyInRN;

  always_comb begin
    stb.wrLeft  = enL && !weLN && !blockL;
    stb.wrRight = enR && !weRN && !blockR;
    stb.rdLeft  = enL && weLN && !oeLN;
    stb.rdRight = enR && weRN && !oeRN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastEnL   <= 1'b0;
      lastEnR   <= 1'b0;
      lastAddrL <= '0;
      lastAddrR <= '0;
      matchQ    <= 1'b0;
      loserQ    <= SIDE_RIGHT;
      busyLN    <= 1'b1;
      busyRN    <= 1'b1;
    end else begin
      lastEnL   <= enL;
      lastEnR   <= enR;
      lastAddrL <= addrL;
      lastAddrR <= addrR;
      matchQ    <= match;
      loserQ    <= loserNow;
      busyLN    <= !(masterMode && match && loserNow == SIDE_LEFT);
      busyRN    <= !(masterMode && match && loserNow == SIDE_RIGHT);
    end
  end

  logic setIntL, clrIntL, setIntR, clrIntR;
  assign setIntR = stb.wrLeft  && (addrL == BOX_OF_RIGHT);
  assign clrIntR = stb.rdRight && (addrR == BOX_OF_RIGHT);
  assign setIntL = stb.wrRight && (addrR == BOX_OF_LEFT);
  assign clrIntL = stb.rdLeft  && (addrL == BOX_OF_LEFT);

  dpram_irq_flag u_irqLeft (
    .clk(clk), .rstN(rstN), .setReq(setIntL), .clrReq(clrIntL), .flagN(intLN)
  );
  dpram_irq_flag u_irqRight (
    .clk(clk), .rstN(rstN), .setReq(setIntR), .clrReq(clrIntR), .flagN(intRN)
  );

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpram_mailbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  output logic [DATA_W-1:0] leftRdData,
  input  logic              leftBusyInN,
  output logic              leftBusyN,
  output logic              leftIntN,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] rightRdData,
  input  logic              rightBusyInN,
  output logic              rightBusyN,
  output logic              rightIntN
);

  portStrobe_t stb;

  dpram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .ceLN(leftCeN), .weLN(leftWeN), .oeLN(leftOeN), .addrL(leftAddr),
    .busyInLN(leftBusyInN),
    .ceRN(rightCeN), .weRN(rightWeN), .oeRN(rightOeN), .addrR(rightAddr),
    .busyInRN(rightBusyInN),
    .stb(stb),
    .busyLN(leftBusyN), .busyRN(rightBusyN),
    .intLN(leftIntN), .intRN(rightIntN)
  );

  dpram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addrL(leftAddr), .addrR(rightAddr),
    .wrDataL(leftWrData), .wrDataR(rightWrData),
    .rdDataL(leftRdData), .rdDataR(rightRdData)
  );

endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              leftCeN,
  input logic              leftWeN,
  input logic              leftOeN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftBusyInN,
  input logic              leftBusyN,
  input logic              leftIntN,
  input logic              rightCeN,
  input logic              rightWeN,
  input logic              rightOeN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightBusyInN,
  input logic              rightBusyN,
  input logic              rightIntN
);

  localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

  assert_busy_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyN && !rightBusyN));

  assert_busy_needs_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rightBusyN || !leftBusyN) |->
      $past(masterMode && !leftCeN && !rightCeN && leftAddr == rightAddr));

  assert_slave_busy_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && $past(!masterMode)) |-> (leftBusyN && rightBusyN));

  assert_right_int_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rightIntN) |-> $past(!leftCeN && !leftWeN && leftAddr == TOP));

  assert_right_int_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rightIntN) |-> $past(!rightCeN && rightWeN && !rightOeN && rightAddr == TOP));

  assert_left_int_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(leftIntN) |-> $past(!rightCeN && !rightWeN && rightAddr == NEXT));

  assert_left_int_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(leftIntN) |-> $past(!leftCeN && leftWeN && !leftOeN && leftAddr == NEXT));

  assert_slave_block_left_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !leftBusyInN && !leftCeN && !leftWeN && leftAddr == TOP && rightIntN)
      |=> rightIntN);

  assert_slave_block_right_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !rightBusyInN && !rightCeN && !rightWeN && rightAddr == NEXT && leftIntN)
      |=> leftIntN);

endmodule

bind dpram_mailbox dpram_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .leftCeN(leftCeN), .leftWeN(leftWeN), .leftOeN(leftOeN), .leftAddr(leftAddr),
  .leftBusyInN(leftBusyInN), .leftBusyN(leftBusyN), .leftIntN(leftIntN),
  .rightCeN(rightCeN), .rightWeN(rightWeN), .rightOeN(rightOeN), .rightAddr(rightAddr),
  .rightBusyInN(rightBusyInN), .rightBusyN(rightBusyN), .rightIntN(rightIntN)
);

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP  = 4'd15;
  localparam logic [AW-1:0] NEXT = 4'd14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic lCe = 1'b1, lWe = 1'b1, lOe = 1'b1, lBusyIn = 1'b1;
  logic rCe = 1'b1, rWe = 1'b1, rOe = 1'b1, rBusyIn = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWd = '0, rWd = '0;
  logic [DW-1:0] lRd, rRd;
  logic lBusy, rBusy, lInt, rInt;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftCeN(lCe), .leftWeN(lWe), .leftOeN(lOe), .leftAddr(lAddr),
    .leftWrData(lWd), .leftRdData(lRd), .leftBusyInN(lBusyIn),
    .leftBusyN(lBusy), .leftIntN(lInt),
    .rightCeN(rCe), .rightWeN(rWe), .rightOeN(rOe), .rightAddr(rAddr),
    .rightWrData(rWd), .rightRdData(rRd), .rightBusyInN(rBusyIn),
    .rightBusyN(rBusy), .rightIntN(rInt)
  );

  typedef struct packed {
    logic [AW-1:0] la;
    logic [DW-1:0] ld;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  8'hA5, 4'd1,  8'h5A},
    '{4'd2,  8'hFF, 4'd3,  8'h00},
    '{4'd4,  8'h01, 4'd13, 8'h80},
    '{4'd13, 8'h3C, 4'd4,  8'hC3},
    '{4'd10, 8'h77, 4'd11, 8'h88},
    '{4'd12, 8'h0F, 4'd5,  8'hF0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic driveL(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    lCe = ce; lWe = we; lOe = oe; lAddr = a; lWd = d;
  endtask

  task automatic driveR(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    rCe = ce; rWe = we; rOe = oe; rAddr = a; rWd = d;
  endtask

  task automatic idle();
    driveL(1, 1, 1, '0, '0);
    driveR(1, 1, 1, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    check("R1 leftBusyN", lBusy, 1);
    check("R1 rightBusyN", rBusy, 1);
    check("R1 leftIntN", lInt, 1);
    check("R1 rightIntN", rInt, 1);
    check("R1 leftRdData", lRd, 0);
    check("R1 rightRdData", rRd, 0);
    driveL(0, 1, 0, NEXT, 0); driveR(0, 1, 0, TOP, 0); tick();
    check("R1 left mailbox word", lRd, 0);
    check("R1 right mailbox word", rRd, 0);
    idle(); tick();

    // table walk: R2 latency/hold, R3 dual write and shared read
    for (int i = 0; i < 6; i++) begin
      driveL(0, 0, 1, VECS[i].la, VECS[i].ld);
      driveR(0, 0, 1, VECS[i].ra, VECS[i].rd);
      tick();
      driveL(0, 1, 0, VECS[i].ra, 0);
      driveR(0, 1, 0, VECS[i].la, 0);
      tick();
      check("R3 left reads right write", lRd, VECS[i].rd);
      check("R2 right reads left write", rRd, VECS[i].ld);
      driveL(0, 1, 0, VECS[i].la, 0);
      driveR(0, 1, 0, VECS[i].la, 0);
      tick();
      check("R3 same-word left", lRd, VECS[i].ld);
      check("R3 same-word right", rRd, VECS[i].ld);
      driveL(0, 1, 1, VECS[i].ra, 0);
      driveR(1, 1, 0, VECS[i].ra, 0);
      tick();
      check("R2 hold left", lRd, VECS[i].ld);
      check("R2 hold right", rRd, VECS[i].ld);
      idle(); tick();
    end

    // R4 right mailbox
    driveL(0, 0, 1, TOP, 8'h5A); tick();
    check("R4 rightIntN set", rInt, 0);
    check("R4 leftIntN untouched", lInt, 1);
    idle(); tick();
    check("R4 rightIntN holds", rInt, 0);
    driveR(0, 1, 0, TOP, 0); tick();
    check("R4 mailbox data", rRd, 8'h5A);
    check("R4 rightIntN cleared", rInt, 1);
    idle(); tick();

    // R5 left mailbox
    driveR(0, 0, 1, NEXT, 8'hC3); tick();
    check("R5 leftIntN set", lInt, 0);
    driveL(0, 1, 0, NEXT, 0); driveR(1, 1, 1, 0, 0); tick();
    check("R5 mailbox data", lRd, 8'hC3);
    check("R5 leftIntN cleared", lInt, 1);
    idle(); tick();

    // R6 set beats clear
    driveL(0, 0, 1, TOP, 8'h11); tick();
    driveL(0, 0, 1, TOP, 8'h12); driveR(0, 1, 0, TOP, 0); tick();
    check("R6 set wins", rInt, 0);
    idle(); tick();
    driveR(0, 1, 0, TOP, 0); tick();
    check("R6 later clear", rInt, 1);
    check("R6 latest mailbox data", rRd, 8'h12);
    idle(); tick();

    // R7 simultaneous arrival: right loses
    driveL(0, 1, 0, 4'd3, 0); driveR(0, 1, 0, 4'd3, 0); tick();
    check("R7 rightBusyN low", rBusy, 0);
    check("R7 leftBusyN high", lBusy, 1);
    tick();
    check("R7 busy held", rBusy, 0);
    driveL(1, 1, 1, 4'd3, 0); tick();
    check("R7 busy released", rBusy, 1);
    idle(); tick();

    // R8 right held the word first: left loses
    driveR(0, 1, 0, 4'd5, 0); tick();
    driveL(0, 1, 0, 4'd5, 0); tick();
    check("R8 leftBusyN low", lBusy, 0);
    check("R8 rightBusyN high", rBusy, 1);
    idle(); tick();
    check("R8 released", lBusy, 1);

    // R9 loser's write is dropped
    driveL(0, 0, 1, 4'd6, 8'h11); driveR(0, 0, 1, 4'd6, 8'h22); tick();
    idle(); tick();
    driveL(0, 1, 0, 4'd6, 0); tick();
    check("R9 left wins simultaneous", lRd, 8'h11);
    idle(); tick();
    driveR(0, 1, 0, 4'd7, 0); tick();
    driveL(0, 0, 1, 4'd7, 8'h33); driveR(0, 0, 1, 4'd7, 8'h44); tick();
    idle(); tick();
    driveL(0, 1, 0, 4'd7, 0); tick();
    check("R9 incumbent right wins", lRd, 8'h44);
    idle(); tick();

    // R10 slave mode
    driveL(0, 0, 1, 4'd8, 8'h10); tick();
    idle(); masterMode = 1'b0; tick();
    lBusyIn = 1'b0;
    driveL(0, 0, 1, 4'd8, 8'h77); tick();
    check("R10 leftBusyN high", lBusy, 1);
    check("R10 rightBusyN high", rBusy, 1);
    driveL(0, 1, 0, 4'd8, 0); tick();
    check("R10 blocked write", lRd, 8'h10);
    driveL(0, 0, 1, TOP, 8'hEE); tick();
    check("R10 blocked mailbox write", rInt, 1);
    lBusyIn = 1'b1;
    driveL(0, 1, 0, 4'd2, 0); driveR(0, 1, 0, 4'd2, 0); tick();
    tick();
    check("R10 collision no busy left", lBusy, 1);
    check("R10 collision no busy right", rBusy, 1);
    driveL(0, 0, 1, 4'd8, 8'h66); driveR(1, 1, 1, 0, 0); tick();
    driveL(0, 1, 0, 4'd8, 0); tick();
    check("R10 unblocked write", lRd, 8'h66);
    idle(); tick();

    // R11 busy inputs ignored in master mode
    masterMode = 1'b1; lBusyIn = 1'b0; rBusyIn = 1'b0; tick();
    driveL(0, 0, 1, 4'd9, 8'h99); driveR(0, 0, 1, 4'd10, 8'hAB); tick();
    driveL(0, 1, 0, 4'd10, 0); driveR(0, 1, 0, 4'd9, 0); tick();
    check("R11 left write stored", rRd, 8'h99);
    check("R11 right write stored", lRd, 8'hAB);
    idle(); tick();

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule